// File: doc/BRIEF.md
# Two-Channel DMA Request Arbiter

This block sits in front of a two-channel DMA engine and decides which channel owns the next bus transfer. Each channel has an enable bit, a priority bit, and a bit that selects its request line: the internal line or its own external line. A module-level source select decides what drives the two internal lines. Either one shared timer request feeds both, or the serial transmitter feeds channel 0 and the serial receiver feeds channel 1. The source select only routes signals. Each channel's own line select still decides which line that channel obeys.

When the two priority bits differ, the high channel always wins a contested decision. When they are equal, a rotation pointer names the favoured channel. The pointer favours channel 1 out of reset. A channel that finishes a transfer in rotating mode hands the favoured slot to the other channel, so two channels that both keep requesting alternate. A decision is made only while the bus is idle. The grant then holds until `xfer_done`.

A channel that is synchronized on its destination can leave the bus in the gap between its source and destination cycles, and it signals this with `owner_gap`. If the other channel is requesting at that moment, the other channel takes the bus for one transfer. After that transfer, the grant returns to the suspended owner.

Top module: `dma_pair_arbiter`

## Requirements
- R1: A synchronous active-high `rst` clears `grant` and `grant_vld`, and sets the rotation pointer to channel 1 (parameter `RESET_HI_CH`).
- R2: If `ch_prio` bits differ (1 = high) and both channels request while idle, the channel whose bit is 1 is granted.
- R3: If `ch_prio` bits are equal and both request at the first decision after reset, channel 1 (`grant` = 2'b10) is granted.
- R4: In rotating mode, completing a transfer makes the other channel favoured, so two channels that keep requesting alternate grants.
- R5: With `src_sel` = 0, the internal line of both channels is `tmr_req`.
- R6: With `src_sel` = 1, the internal line of channel 0 is `ser_tx_req` and that of channel 1 is `ser_rx_req`.
- R7: `ch_use_int[i]` = 1 makes channel i obey its internal line, and 0 makes it obey `ext_req[i]`, whatever `src_sel` is.
- R8: A channel with `ch_en[i]` = 0, or whose selected line is low, is never newly granted. With no request, `grant_vld` stays low.
- R9: `grant` is one-hot (bit i = channel i) while `grant_vld` is 1, and 0 otherwise. It holds until `xfer_done`, and is cleared on the edge that samples `xfer_done`.
- R10: While a transfer is in progress, `owner_gap` high with the other channel requesting moves the grant to the other channel. That channel's `xfer_done` returns the grant to the suspended owner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_en | input | 2 | Per-channel enable |
| ch_prio | input | 2 | Per-channel priority, 1 = high |
| ch_use_int | input | 2 | Per-channel line select, 1 = internal |
| ext_req | input | 2 | Per-channel external request |
| src_sel | input | 1 | Internal source, 0 = timer, 1 = serial |
| tmr_req | input | 1 | Shared timer request |
| ser_tx_req | input | 1 | Serial transmitter request |
| ser_rx_req | input | 1 | Serial receiver request |
| xfer_done | input | 1 | End of the granted transfer |
| owner_gap | input | 1 | Owner has released the bus between its cycles |
| grant | output | 2 | One-hot grant |
| grant_vld | output | 1 | A grant is active |

## Verification
The bench builds the block with `RESET_HI_CH` = 1, which makes the reset favour channel 1. This lets it check the first rotating decision against a fixed expectation. Directed sequences walk through the following cases:
- fixed priority in both directions;
- alternation of two channels that keep requesting;
- each internal source routing;
- an external-line channel that ignores an active timer;
- a borrowed transfer during a gap.

A long random run then mixes these with arbitrary enables, priorities and `xfer_done`/`owner_gap` timing. That run reaches the paths where a borrowed transfer or a mode change meets a pointer update.

// File: rtl/dpa_pkg.sv
package dpa_pkg;
  localparam int unsigned NCH = 2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_LOAN = 2'd2
  } arb_st_t;

  // Winner of one decision: a lone request wins, differing priorities pick
  // the high channel, equal priorities follow the rotation pointer.
  function automatic logic pick_ch(input logic [NCH-1:0] req,
                                   input logic [NCH-1:0] prio,
                                   input logic hi_ptr);
    if (req == 2'b01) return 1'b0;
    if (req == 2'b10) return 1'b1;
    if (prio[0] ^ prio[1]) return prio[1];
    return hi_ptr;
  endfunction

  function automatic logic [NCH-1:0] ch_onehot(input logic ch);
    return ch ? 2'b10 : 2'b01;
  endfunction
endpackage

// File: rtl/dpa_req_route.sv
module dpa_req_route
  import dpa_pkg::*;
(
  input  logic [NCH-1:0] ch_en,
  input  logic [NCH-1:0] ch_use_int,
  input  logic [NCH-1:0] ext_req,
  input  logic           src_sel,
  input  logic           tmr_req,
  input  logic           ser_tx_req,
  input  logic           ser_rx_req,
  output logic [NCH-1:0] int_line,
  output logic [NCH-1:0] req
);
  logic [NCH-1:0] ser_line;
  assign ser_line = {ser_rx_req, ser_tx_req};

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign int_line[i] = src_sel ? ser_line[i] : tmr_req;
    assign req[i]      = ch_en[i] & (ch_use_int[i] ? int_line[i] : ext_req[i]);
  end
endmodule

// File: rtl/dpa_pick.sv
module dpa_pick
  import dpa_pkg::*;
(
  input  logic [NCH-1:0] req,
  input  logic [NCH-1:0] prio,
  input  logic           hi_ptr,
  output logic           any_req,
  output logic           win_ch,
  output logic           rot_mode
);
  assign any_req  = |req;
  assign win_ch   = pick_ch(req, prio, hi_ptr);
  assign rot_mode = ~(prio[0] ^ prio[1]);
endmodule

// File: rtl/dpa_rot_ptr.sv
module dpa_rot_ptr #(
  parameter logic RESET_HI_CH = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic upd,
  input  logic done_ch,
  output logic hi_ptr
);
  always_ff @(posedge clk) begin
    if (rst)      hi_ptr <= RESET_HI_CH;
    else if (upd) hi_ptr <= ~done_ch;
  end

  AST_PTR_HANDOFF: assert property (@(posedge clk) disable iff (rst)
    upd |=> hi_ptr != $past(done_ch)); // R4
endmodule

// File: rtl/dma_pair_arbiter.sv
module dma_pair_arbiter
  import dpa_pkg::*;
#(
  parameter logic RESET_HI_CH = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] ch_en,
  input  logic [1:0] ch_prio,
  input  logic [1:0] ch_use_int,
  input  logic [1:0] ext_req,
  input  logic       src_sel,
  input  logic       tmr_req,
  input  logic       ser_tx_req,
  input  logic       ser_rx_req,
  input  logic       xfer_done,
  input  logic       owner_gap,
  output logic [1:0] grant,
  output logic       grant_vld
);
  arb_st_t        st;
  logic           own_ch;
  logic           held_ch;
  logic [NCH-1:0] int_line;
  logic [NCH-1:0] req;
  logic           any_req;
  logic           win_ch;
  logic           rot_mode;
  logic           hi_ptr;

  // Named internal events
  logic idle_now;
  logic done_now;
  logic ptr_upd;
  logic loan_go;
  logic start_go;

  dpa_req_route u_route (
    .ch_en(ch_en), .ch_use_int(ch_use_int), .ext_req(ext_req),
    .src_sel(src_sel), .tmr_req(tmr_req), .ser_tx_req(ser_tx_req),
    .ser_rx_req(ser_rx_req), .int_line(int_line), .req(req)
  );

  dpa_pick u_pick (
    .req(req), .prio(ch_prio), .hi_ptr(hi_ptr),
    .any_req(any_req), .win_ch(win_ch), .rot_mode(rot_mode)
  );

  dpa_rot_ptr #(.RESET_HI_CH(RESET_HI_CH)) u_ptr (
    .clk(clk), .rst(rst), .upd(ptr_upd), .done_ch(own_ch), .hi_ptr(hi_ptr)
  );

  assign idle_now = (st == ST_IDLE);
  assign done_now = xfer_done && !idle_now;
  assign ptr_upd  = done_now && rot_mode;
  assign start_go = idle_now && any_req;
  assign loan_go  = (st == ST_BUSY) && !xfer_done && owner_gap && req[~own_ch];

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      own_ch  <= 1'b0;
      held_ch <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: if (start_go) begin
          st     <= ST_BUSY;
          own_ch <= win_ch;
        end
        ST_BUSY: begin
          if (xfer_done) st <= ST_IDLE;
          else if (loan_go) begin
            st      <= ST_LOAN;
            held_ch <= own_ch;
            own_ch  <= ~own_ch;
          end
        end
        ST_LOAN: if (xfer_done) begin
          st     <= ST_BUSY;
          own_ch <= held_ch;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign grant_vld = !idle_now;
  assign grant     = idle_now ? 2'b00 : ch_onehot(own_ch);

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!grant_vld && grant == 2'b00 && hi_ptr == RESET_HI_CH)); // R1
  AST_FIXED_WINS: assert property (@(posedge clk) disable iff (rst)
    (idle_now && req == 2'b11 && (ch_prio[0] ^ ch_prio[1])) |=> grant == $past(ch_prio)); // R2
  AST_NO_REQ_NO_GRANT: assert property (@(posedge clk) disable iff (rst)
    (idle_now && req == 2'b00) |=> !grant_vld); // R8
  AST_GRANT_SHAPE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant) && (grant_vld == (grant != 2'b00))); // R9
  AST_GRANT_HELD: assert property (@(posedge clk) disable iff (rst)
    (grant_vld && !xfer_done && !loan_go) |=> $stable(grant)); // R9
  AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (rst)
    ((st == ST_BUSY) && xfer_done) |=> !grant_vld); // R9
  AST_LOAN_RETURN: assert property (@(posedge clk) disable iff (rst)
    ((st == ST_LOAN) && xfer_done) |=> grant == ch_onehot($past(held_ch))); // R10
endmodule

// File: tb/sim_dma_pair_arbiter.sv
module sim_dma_pair_arbiter;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] ch_en = '0, ch_prio = '0, ch_use_int = '0, ext_req = '0;
  logic src_sel = 0, tmr_req = 0, ser_tx_req = 0, ser_rx_req = 0;
  logic xfer_done = 0, owner_gap = 0;
  logic [1:0] grant;
  logic grant_vld;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk; // 50 MHz

  dma_pair_arbiter #(.RESET_HI_CH(1'b1)) u0 (
    .clk(clk), .rst(rst), .ch_en(ch_en), .ch_prio(ch_prio),
    .ch_use_int(ch_use_int), .ext_req(ext_req), .src_sel(src_sel),
    .tmr_req(tmr_req), .ser_tx_req(ser_tx_req), .ser_rx_req(ser_rx_req),
    .xfer_done(xfer_done), .owner_gap(owner_gap),
    .grant(grant), .grant_vld(grant_vld)
  );

  // Reference model state: 0 idle, 1 busy, 2 borrowed
  int m_st = 0;
  bit m_own = 0, m_held = 0, m_ptr = 1;

  function automatic bit b_line(bit use_int, bit ext, bit ssel, bit tm, bit ser);
    bit internal_v;
    internal_v = (ssel == 1'b0) ? tm : ser;
    return use_int ? internal_v : ext;
  endfunction

  function automatic logic [1:0] b_req();
    logic [1:0] r;
    r[0] = ch_en[0] && b_line(ch_use_int[0], ext_req[0], src_sel, tmr_req, ser_tx_req);
    r[1] = ch_en[1] && b_line(ch_use_int[1], ext_req[1], src_sel, tmr_req, ser_rx_req);
    return r;
  endfunction

  function automatic bit b_win(logic [1:0] r, logic [1:0] p, bit ptr);
    if (r[0] && !r[1]) return 1'b0;
    if (r[1] && !r[0]) return 1'b1;
    if (p[0] != p[1]) return p[0] ? 1'b0 : 1'b1;
    return ptr;
  endfunction

  task automatic model_step();
    logic [1:0] r;
    bit equal_p;
    r = b_req();
    equal_p = (ch_prio[0] == ch_prio[1]);
    case (m_st)
      0: if (r != 2'b00) begin m_own = b_win(r, ch_prio, m_ptr); m_st = 1; end
      1: begin
        if (xfer_done) begin
          if (equal_p) m_ptr = !m_own;
          m_st = 0;
        end else if (owner_gap && r[!m_own]) begin
          m_held = m_own; m_own = !m_own; m_st = 2;
        end
      end
      default: if (xfer_done) begin
        if (equal_p) m_ptr = !m_own;
        m_own = m_held; m_st = 1;
      end
    endcase
  endtask

  task automatic compare(input string tag);
    logic [1:0] eg;
    bit ev;
    ev = (m_st != 0);
    eg = ev ? (m_own ? 2'b10 : 2'b01) : 2'b00;
    checks++;
    if (grant !== eg || grant_vld !== ev) begin
      errors++;
      $display("FAIL %s: grant=%b vld=%b expected grant=%b vld=%b",
               tag, grant, grant_vld, eg, ev);
    end
  endtask

  task automatic cyc(input logic [1:0] en, input logic [1:0] pr, input logic [1:0] ui,
                     input logic [1:0] ex, input logic ss, input logic tm,
                     input logic tx, input logic rx, input logic dn, input logic gp,
                     input string tag);
    ch_en = en; ch_prio = pr; ch_use_int = ui; ext_req = ex;
    src_sel = ss; tmr_req = tm; ser_tx_req = tx; ser_rx_req = rx;
    xfer_done = dn; owner_gap = gp;
    model_step();
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    compare("R1 reset state");
    // R3: equal priority, first contest goes to channel 1
    cyc(2'b11, 2'b00, 2'b00, 2'b11, 0, 0, 0, 0, 0, 0, "R3 first rotating grant");
    cyc(2'b11, 2'b00, 2'b00, 2'b00, 0, 0, 0, 0, 0, 0, "R9 grant held");
    cyc(2'b11, 2'b00, 2'b00, 2'b11, 0, 0, 0, 0, 1, 0, "R9 done releases");
    // R4: alternation
    cyc(2'b11, 2'b11, 2'b00, 2'b11, 0, 0, 0, 0, 0, 0, "R4 alternate to ch0");
    cyc(2'b11, 2'b11, 2'b00, 2'b11, 0, 0, 0, 0, 1, 0, "R4 done ch0");
    cyc(2'b11, 2'b11, 2'b00, 2'b11, 0, 0, 0, 0, 0, 0, "R4 alternate to ch1");
    cyc(2'b11, 2'b11, 2'b00, 2'b11, 0, 0, 0, 0, 1, 0, "R4 done ch1");
    // R2: fixed priority both ways
    cyc(2'b11, 2'b01, 2'b00, 2'b11, 0, 0, 0, 0, 0, 0, "R2 ch0 high wins");
    cyc(2'b11, 2'b01, 2'b00, 2'b11, 0, 0, 0, 0, 1, 0, "R2 done");
    cyc(2'b11, 2'b01, 2'b00, 2'b11, 0, 0, 0, 0, 0, 0, "R2 ch0 high wins again");
    cyc(2'b11, 2'b10, 2'b00, 2'b11, 0, 0, 0, 0, 1, 0, "R2 done");
    cyc(2'b11, 2'b10, 2'b00, 2'b11, 0, 0, 0, 0, 0, 0, "R2 ch1 high wins");
    cyc(2'b11, 2'b10, 2'b00, 2'b00, 0, 0, 0, 0, 1, 0, "R2 done");
    // R5: timer feeds internal lines
    cyc(2'b01, 2'b00, 2'b11, 2'b00, 0, 1, 0, 0, 0, 0, "R5 timer to ch0");
    cyc(2'b01, 2'b00, 2'b11, 2'b00, 0, 1, 0, 0, 1, 0, "R5 done");
    cyc(2'b10, 2'b00, 2'b11, 2'b00, 0, 1, 0, 0, 0, 0, "R5 timer to ch1");
    cyc(2'b10, 2'b00, 2'b11, 2'b00, 0, 0, 0, 0, 1, 0, "R5 done");
    // R6: serial routing
    cyc(2'b11, 2'b00, 2'b11, 2'b00, 1, 1, 0, 1, 0, 0, "R6 rx to ch1 only");
    cyc(2'b11, 2'b00, 2'b11, 2'b00, 1, 0, 0, 0, 1, 0, "R6 done");
    cyc(2'b11, 2'b00, 2'b11, 2'b00, 1, 1, 1, 0, 0, 0, "R6 tx to ch0 only");
    cyc(2'b11, 2'b00, 2'b11, 2'b00, 1, 0, 0, 0, 1, 0, "R6 done");
    // R7: external-line channel ignores active internal sources
    cyc(2'b11, 2'b00, 2'b00, 2'b00, 0, 1, 1, 1, 0, 0, "R7 external lines low, no grant");
    cyc(2'b11, 2'b00, 2'b10, 2'b01, 1, 1, 0, 0, 0, 0, "R7 ch0 obeys ext, ch1 sees low rx");
    cyc(2'b11, 2'b00, 2'b10, 2'b00, 1, 0, 0, 0, 1, 0, "R7 done");
    // R8: disabled channels
    cyc(2'b00, 2'b00, 2'b01, 2'b11, 0, 1, 1, 1, 0, 0, "R8 disabled, no grant");
    cyc(2'b00, 2'b00, 2'b00, 2'b00, 0, 0, 0, 0, 0, 0, "R8 still idle");
    // R10: borrowed transfer during a gap
    cyc(2'b11, 2'b10, 2'b00, 2'b10, 0, 0, 0, 0, 0, 0, "R10 ch1 owns");
    cyc(2'b11, 2'b10, 2'b00, 2'b01, 0, 0, 0, 0, 0, 1, "R10 gap lends to ch0");
    cyc(2'b11, 2'b10, 2'b00, 2'b01, 0, 0, 0, 0, 0, 1, "R10 loan held");
    cyc(2'b11, 2'b10, 2'b00, 2'b00, 0, 0, 0, 0, 1, 0, "R10 return to ch1");
    cyc(2'b11, 2'b10, 2'b00, 2'b00, 0, 0, 0, 0, 1, 0, "R10 owner done");
    // Random mix
    for (int n = 0; n < 4000; n++) begin
      cyc(2'($urandom()), 2'($urandom()), 2'($urandom()), 2'($urandom()),
          1'($urandom()), 1'($urandom()), 1'($urandom()), 1'($urandom()),
          ($urandom() % 4) == 0, ($urandom() % 6) == 0, "R9 random");
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule